// File: doc/BRIEF.md
# Timer/Event Counter with Single-Shot Pulse Capture

An 8-bit up-counter for a small processor subsystem. Software reaches it through a register bus with three addresses: the count (write side is the preload), the control word, and the sticky interrupt flag. The counter has three working modes. Timer mode advances on ticks of a free-running prescaler that divides the system clock by a power of two. Event mode advances on a chosen transition of an external pin. Width mode waits for one start transition on that pin, then counts prescaled ticks until the opposite transition. After that one measurement it clears its own run bit.

When the count passes 0xFF it reloads from the preload register. This raises a one-cycle overflow pulse, toggles a divide-by-two output, and sets a sticky interrupt flag if the interrupt enable input is high. The pin passes through a two-flop synchroniser before its edges are detected. A read of the count holds the counter still for that cycle, so software sees a stable value.

Top module: `tec_timer`

## Requirements
- R1: After reset the count, the preload, the control word, the interrupt flag, the overflow pulse and the divide-by-two output are all 0.
- R2: Control field div_sel (bits 2:0, code k) sets the tick rate to one tick every 2^k system clocks. In timer mode (mode field bits 7:6 = 10) with run (bit 4) set, the count advances by one per tick.
- R3: When an increment takes the count past 0xFF, the count becomes the preload value. The overflow output goes high for exactly one cycle, and the divide-by-two output toggles.
- R4: An overflow sets the interrupt flag (address 2, bit 0, also on irq_req) only when irq_en is 1. The flag stays set until any write to address 2 clears it.
- R5: A write to address 0 while run is 0 loads both the preload and the count. While run is 1 it loads only the preload, and the count keeps counting from its current value.
- R6: In event mode (mode = 01), edge_sel (bit 3) = 0 counts rising edges of ev_pin and edge_sel = 1 counts falling edges.
- R7: In width mode (mode = 11), edge_sel = 1 starts on a rising edge and stops on the next falling edge. edge_sel = 0 starts on a falling edge and stops on a rising edge. With div_sel = 0, a pulse of L clocks adds exactly L to the count.
- R8: In width mode, run clears itself when the stop edge arrives, and later pulses leave the count unchanged until software sets run again. In the other modes, run changes only when software writes it.
- R9: In a cycle where address 0 is read, the count does not change, and reads on consecutive cycles return the same value.
- R10: Control bit 5 always reads as 0. In mode 00 the count does not advance, even with run set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of address 0 blocks counting for that cycle |
| bus_addr | input | 2 | 0 = count/preload, 1 = control, 2 = interrupt flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ev_pin | input | 1 | External event / pulse input, asynchronous |
| irq_en | input | 1 | Interrupt enable; when 0, overflows do not set the flag |
| irq_req | output | 1 | Sticky interrupt flag |
| ovf_pulse | output | 1 | One-cycle pulse on each overflow |
| half_out | output | 1 | Toggles on every overflow |

## Verification
The hardest case to reach is the width-mode measurement. The pin edge has to cross the synchroniser and start the count, and the stop edge has to clear run in the same cycle as the last increment. If the bench is off by one cycle here, the captured width is wrong. The bench arms the block and then drives pulses of every length from 1 to 12 clocks, for both edge polarities, and checks that the captured count equals the length. It then sends a further pulse with run cleared and confirms the count stays put, and finally re-arms to show that the count accumulates. Overflow and preload-while-running are reached by loading counts a few steps below 0xFF.

// File: rtl/tec_pkg.sv
package tec_pkg;

    localparam int BUS_W   = 8;
    localparam int SEL_W   = 3;
    localparam int SYNC_N  = 2;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_WIDTH = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e            mode;
        logic             rsvd;
        logic             run;
        logic             edge_sel;
        logic [SEL_W-1:0] div_sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        ADR_COUNT = 2'd0,
        ADR_CTRL  = 2'd1,
        ADR_FLAG  = 2'd2
    } addr_e;

    // Edge that advances the counter in event mode
    function automatic logic event_edge(input logic sel, input logic rise, input logic fall);
        return sel ? fall : rise;
    endfunction

endpackage

// File: rtl/tec_prescaler.sv
module tec_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // Low 'sel' bits of the mask are set; a tick fires when they are all ones
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (sel > SEL_W'(i));
    end

    assign tick = ((div_q & mask) == mask);

endmodule

// File: rtl/tec_edge_det.sv
module tec_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], pin};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

endmodule

// File: rtl/tec_count.sv
module tec_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         wr,
    input  logic         running,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         ovf,
    output logic         half
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] pre_q;
    logic         ovf_q;
    logic         half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pre_q  <= '0;
            ovf_q  <= 1'b0;
            half_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (wr) pre_q <= wdata;
            if (wr && !running) begin
                cnt_q <= wdata;
            end else if (inc) begin
                if (cnt_q == {W{1'b1}}) begin
                    cnt_q  <= pre_q;
                    ovf_q  <= 1'b1;
                    half_q <= ~half_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cnt  = cnt_q;
    assign ovf  = ovf_q;
    assign half = half_q;

    // R3: overflow reloads from the preload held before that edge
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> cnt_q == $past(pre_q));

    // R3: divide-by-two output moves only with an overflow
    p_half_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> half_q != $past(half_q));

    p_half_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !ovf_q |-> $stable(half_q));

    // R5: a write while running leaves the count alone
    p_preload_run_r5: assert property (@(posedge clk) disable iff (rst)
        $past(wr && running && !inc) |-> $stable(cnt_q));

endmodule

// File: rtl/tec_timer.sv
module tec_timer
    import tec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ev_pin,
    input  logic             irq_en,
    output logic             irq_req,
    output logic             ovf_pulse,
    output logic             half_out
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic             active_q;
    logic             irq_q;
    logic             tick;
    logic             rise;
    logic             fall;
    logic             inc;
    logic [BUS_W-1:0] cnt;
    logic             ovf;
    logic             half;

    logic wr_cnt, wr_ctrl, wr_flag, rd_blk;
    logic start_edge, stop_edge;

    assign wr_cnt  = bus_wr && (bus_addr == ADR_COUNT);
    assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_flag = bus_wr && (bus_addr == ADR_FLAG);
    assign rd_blk  = bus_rd && (bus_addr == ADR_COUNT);

    tec_prescaler #(.SEL_W(SEL_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .sel  (ctrl_q.div_sel),
        .tick (tick)
    );

    tec_edge_det #(.STAGES(SYNC_N)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (ev_pin),
        .rise (rise),
        .fall (fall)
    );

    assign start_edge = ctrl_q.edge_sel ? rise : fall;
    assign stop_edge  = ctrl_q.edge_sel ? fall : rise;

    always_comb begin
        case (ctrl_q.mode)
            MODE_TIMER: inc = ctrl_q.run & tick;
            MODE_EVENT: inc = ctrl_q.run & event_edge(ctrl_q.edge_sel, rise, fall);
            MODE_WIDTH: inc = active_q & tick;
            default:    inc = 1'b0;
        endcase
        if (rd_blk) inc = 1'b0;
    end

    always_comb begin
        ctrl_new      = ctrl_t'(bus_wdata);
        ctrl_new.rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            active_q <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q   <= ctrl_new;
            active_q <= 1'b0;
        end else if (ctrl_q.mode == MODE_WIDTH && ctrl_q.run) begin
            if (!active_q && start_edge) begin
                active_q <= 1'b1;
            end else if (active_q && stop_edge) begin
                active_q   <= 1'b0;
                ctrl_q.run <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                 irq_q <= 1'b0;
        else if (ovf && irq_en)  irq_q <= 1'b1;
        else if (wr_flag)        irq_q <= 1'b0;
    end

    tec_count #(.W(BUS_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (inc),
        .wr      (wr_cnt),
        .running (ctrl_q.run),
        .wdata   (bus_wdata),
        .cnt     (cnt),
        .ovf     (ovf),
        .half    (half)
    );

    always_comb begin
        case (bus_addr)
            ADR_COUNT: bus_rdata = cnt;
            ADR_CTRL:  bus_rdata = ctrl_q;
            ADR_FLAG:  bus_rdata = {{(BUS_W-1){1'b0}}, irq_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_req   = irq_q;
    assign ovf_pulse = ovf;
    assign half_out  = half;

    // R4: the flag rises only on an enabled overflow
    p_flag_gate_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(irq_en) && $past(ovf));

    // R9: a count read freezes the counter for that cycle
    p_read_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rd_blk && !wr_cnt) |-> cnt == $past(cnt));

    // R8: run drops without a software write only in width mode
    p_run_self_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctrl_q.run) && !$past(wr_ctrl)) |-> $past(ctrl_q.mode) == MODE_WIDTH);

    // R10: reserved control bit never reads back set
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADR_CTRL) |-> bus_rdata[5] == 1'b0);

endmodule

// File: tb/tec_timer_tb.sv
module tec_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ev_pin = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq_req;
    logic       ovf_pulse;
    logic       half_out;

    int checks = 0;
    int errors = 0;
    int ovf_seen = 0;
    bit done = 0;

    tec_timer u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_pin(ev_pin), .irq_en(irq_en), .irq_req(irq_req),
        .ovf_pulse(ovf_pulse), .half_out(half_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (!rst && ovf_pulse) ovf_seen++;

    // control word helpers: mode[7:6] run[4] edge[3] div[2:0]
    function automatic logic [7:0] cw(input logic [1:0] m, input logic run,
                                      input logic es, input logic [2:0] d);
        return {m, 1'b0, run, es, d};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic lvl, input int len, input int gap);
        ev_pin = lvl; idle(len);
        ev_pin = ~lvl; idle(gap);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        int o0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 count", v, 0);
        rd(2'd1, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", irq_req, 0);
        chk("R1 half", half_out, 0);
        chk("R1 ovf", ovf_pulse, 0);

        // R10 reserved bit and mode 00
        wr(2'd1, 8'h2A); rd(2'd1, v); chk("R10 rsvd bit", v, 8'h0A);
        wr(2'd1, 8'h00); wr(2'd0, 8'h33);
        wr(2'd1, 8'h10); idle(20);
        rd(2'd0, v); chk("R10 mode00 no count", v, 8'h33);
        rd(2'd1, v); chk("R10 ctrl readback", v, 8'h10);
        wr(2'd1, 8'h00);

        // R2 prescaler sweep in timer mode
        for (int k = 0; k < 8; k++) begin
            for (int m = 3; m <= 5; m += 2) begin
                wr(2'd1, cw(2'b10, 0, 0, 3'(k)));
                wr(2'd0, 8'h00);
                wr(2'd1, cw(2'b10, 1, 0, 3'(k)));
                idle((m << k) - 1);
                wr(2'd1, cw(2'b10, 0, 0, 3'(k)));
                rd(2'd0, v); chk($sformatf("R2 div code %0d", k), v, m);
            end
        end

        // R3 / R4 overflow with interrupt enabled
        irq_en = 1'b1;
        wr(2'd1, cw(2'b10, 0, 0, 3'd0));
        wr(2'd0, 8'hFC);
        wr(2'd2, 8'h00);
        o0 = ovf_seen;
        wr(2'd1, cw(2'b10, 1, 0, 3'd0)); idle(3);
        wr(2'd1, cw(2'b10, 0, 0, 3'd0));
        idle(2);
        rd(2'd0, v); chk("R3 reload value", v, 8'hFC);
        chk("R3 one ovf pulse", ovf_seen - o0, 1);
        chk("R3 half toggled", half_out, 1);
        rd(2'd2, v); chk("R4 flag set", v, 1);
        idle(5); chk("R4 flag sticky", irq_req, 1);
        wr(2'd2, 8'h00); idle(1);
        chk("R4 flag cleared", irq_req, 0);

        // R4 overflow with interrupt disabled
        irq_en = 1'b0;
        wr(2'd1, cw(2'b10, 1, 0, 3'd0)); idle(3);
        wr(2'd1, cw(2'b10, 0, 0, 3'd0));
        idle(2);
        chk("R3 second ovf", ovf_seen - o0, 2);
        chk("R3 half back", half_out, 0);
        chk("R4 flag masked", irq_req, 0);

        // R5 write while stopped vs running
        wr(2'd0, 8'h5A); rd(2'd0, v); chk("R5 stopped load", v, 8'h5A);
        wr(2'd0, 8'hFD);
        wr(2'd1, cw(2'b10, 1, 0, 3'd0));
        wr(2'd0, 8'h20);
        wr(2'd1, cw(2'b10, 0, 0, 3'd0));
        rd(2'd0, v); chk("R5 running write keeps count", v, 8'hFF);
        wr(2'd1, cw(2'b10, 1, 0, 3'd0));
        wr(2'd1, cw(2'b10, 0, 0, 3'd0));
        rd(2'd0, v); chk("R5 new preload on ovf", v, 8'h20);

        // R9 read blocking
        wr(2'd0, 8'h40);
        wr(2'd1, cw(2'b10, 1, 0, 3'd0));
        rd(2'd0, v);
        for (int i = 0; i < 6; i++) begin
            rd(2'd0, v2); chk("R9 stable read", v2, v);
        end
        wr(2'd1, cw(2'b10, 0, 0, 3'd0));
        rd(2'd0, v); chk("R9 blocked ticks lost", v, 8'h41);

        // R6 event mode, both edges; 5 rises and 4 falls
        for (int es = 0; es < 2; es++) begin
            ev_pin = 1'b0; idle(6);
            wr(2'd1, cw(2'b01, 0, es[0], 3'd0));
            wr(2'd0, 8'h00);
            wr(2'd1, cw(2'b01, 1, es[0], 3'd0));
            for (int i = 0; i < 4; i++) pulse(1'b1, (i % 3) + 1, (i % 2) + 2);
            ev_pin = 1'b1; idle(6);
            wr(2'd1, cw(2'b01, 0, es[0], 3'd0));
            rd(2'd0, v);
            chk(es ? "R6 falling edges" : "R6 rising edges", v, es ? 4 : 5);
            rd(2'd1, v); chk("R8 event run kept", v[4], 0);
        end
        ev_pin = 1'b0; idle(6);

        // R7 width mode, both polarities, lengths 1..12
        for (int es = 1; es >= 0; es--) begin
            for (int len = 1; len <= 12; len++) begin
                ev_pin = (es == 0); idle(6);
                wr(2'd1, cw(2'b11, 0, es[0], 3'd0));
                wr(2'd0, 8'h00);
                wr(2'd1, cw(2'b11, 1, es[0], 3'd0));
                idle(3);
                pulse(es[0], len, 6);
                rd(2'd0, v); chk($sformatf("R7 width %0d edge %0d", len, es), v, len);
                rd(2'd1, v); chk("R8 run self-cleared", v, {2'b11, 3'b000, 3'b000} | {4'b0, es[0], 3'b0});
            end
        end
        ev_pin = 1'b0; idle(6);

        // R8 single shot, then re-arm accumulates
        wr(2'd1, cw(2'b11, 0, 1, 3'd0));
        wr(2'd0, 8'h00);
        wr(2'd1, cw(2'b11, 1, 1, 3'd0)); idle(3);
        pulse(1'b1, 5, 6);
        pulse(1'b1, 7, 6);
        rd(2'd0, v); chk("R8 second pulse ignored", v, 5);
        wr(2'd1, cw(2'b11, 1, 1, 3'd0)); idle(3);
        pulse(1'b1, 3, 6);
        rd(2'd0, v); chk("R8 re-armed accumulates", v, 8);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule